// File: doc/BRIEF.md
# Delay-Line Coincidence Detector

This block watches eleven detector channels and reports which of them fired together. Each channel supplies two asynchronous levels: a prompt pulse straight from the detector and a copy of that pulse that an external programmable delay line has shifted later in time. The first delayed copy to rise, on any channel, sets the sampling moment. On that clock cycle the block takes a snapshot of the prompt levels and turns it into an eleven-bit coincidence word, one bit per channel.

After each capture the block locks itself out. It stays locked until every prompt level has dropped, and only then does it arm again. Because of this, a single burst of detector activity produces at most one word. Each reported word is presented for one cycle, together with a valid strobe, to a downstream bank of counters. A run input lets the surrounding system pause detection while it reads those counters. Detection starts again once run returns and the channels are quiet.

The control logic is a three-state machine. PAUSED holds while run is low. ARMED waits for a delayed edge. LOCKOUT waits for all prompts to be low. The transitions are:
- RESUME goes from PAUSED to LOCKOUT when run is high.
- REARM goes from LOCKOUT to ARMED when all prompts are low.
- FIRE goes from ARMED to LOCKOUT on any delayed rising edge.
- PAUSE goes from ARMED or LOCKOUT to PAUSED when run is low.

Top module: `coinc_detect`

## Requirements
- R1: While reset is asserted, and right after it is released, `hit_valid` is 0 and `hit_word` is 0.
- R2: Bit i of `hit_word` is 1 exactly when prompt input i was high at the sampling moment. Channel 0 has weight 1, channel 2 has weight 4, and channel 10 has weight 1024. For example, channels 0 and 2 together give the word 5.
- R3: The sampling moment is the first cycle in which a rising edge of any delayed input is seen. A delayed input that rises on the clock edge k (inputs pass through two synchronizer flops) gives `hit_valid` high after edge k+2. A prompt that rises after the sampling moment is not part of the word, and delayed edges that follow within the same burst do not change the word.
- R4: After a capture, no further word is emitted until every prompt input has been low for at least one synchronized cycle. After that, a new delayed edge produces a new word.
- R5: Delayed rising edges on several channels in the same cycle produce exactly one word.
- R6: A word with only one bit set (a single) is emitted like any other word.
- R7: While `run` is low, no word is emitted, and delayed edges seen during that time are discarded. When `run` returns, detection resumes once all prompts are low.
- R8: `hit_valid` is never high on two consecutive cycles, and a word of 0 is never emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to detect, low to pause (synchronous to clk) |
| prompt_in | input | 11 | Asynchronous prompt level per channel |
| delayed_in | input | 11 | Asynchronous delayed copy per channel |
| hit_valid | output | 1 | One-cycle strobe marking a new coincidence word |
| hit_word | output | 11 | Coincidence word, bit i for channel i |

## Verification
A state machine stuck in LOCKOUT shows up at the ports as a missing word on the next clean burst, within three cycles of that burst's delayed edge. A machine that re-arms too early shows up as a second strobe inside one burst. If the synchronizer or the edge detector fires at the wrong time, the captured word gains or loses late prompts, so the bench raises a late prompt exactly one cycle after the sampling edge. Mishandling of pause is exposed by edges applied while run is low and by prompts that are held high across the moment run resumes.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
    typedef enum logic [1:0] {
        ST_PAUSED  = 2'd0,
        ST_ARMED   = 2'd1,
        ST_LOCKOUT = 2'd2
    } coinc_state_e;
endpackage

// File: rtl/coinc_sync.sv
// Multi-stage level synchronizer for a vector of asynchronous inputs.
module coinc_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/coinc_rise.sv
// Rising-edge detector on synchronized levels.
module coinc_rise #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/coinc_detect.sv
module coinc_detect
    import coinc_pkg::*;
#(
    parameter int NCH         = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [NCH-1:0] prompt_in,
    input  logic [NCH-1:0] delayed_in,
    output logic           hit_valid,
    output logic [NCH-1:0] hit_word
);
    localparam int SW = 2 * NCH;

    logic [SW-1:0]  raw_bus;
    logic [SW-1:0]  sync_bus;
    logic [NCH-1:0] prompt_s;
    logic [NCH-1:0] delayed_s;
    logic [NCH-1:0] delayed_rise;
    logic           any_rise;
    logic           prompts_quiet;
    logic           fire;

    coinc_state_e state_q, state_d;

    assign raw_bus = {delayed_in, prompt_in};

    coinc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign prompt_s  = sync_bus[NCH-1:0];
    assign delayed_s = sync_bus[SW-1:NCH];

    coinc_rise #(.W(NCH)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (delayed_s),
        .rise  (delayed_rise)
    );

    assign any_rise      = |delayed_rise;
    assign prompts_quiet = (prompt_s == '0);
    assign fire          = (state_q == ST_ARMED) && run && any_rise;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSED: begin
                if (run) state_d = ST_LOCKOUT;              // RESUME
            end
            ST_ARMED: begin
                if (!run)          state_d = ST_PAUSED;     // PAUSE
                else if (any_rise) state_d = ST_LOCKOUT;    // FIRE
            end
            ST_LOCKOUT: begin
                if (!run)               state_d = ST_PAUSED;  // PAUSE
                else if (prompts_quiet) state_d = ST_ARMED;   // REARM
            end
            default: state_d = ST_PAUSED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAUSED;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit_word  <= '0;
        end else begin
            hit_valid <= fire && !prompts_quiet;
            if (fire && !prompts_quiet) hit_word <= prompt_s;
        end
    end
endmodule

// File: rtl/coinc_detect_chk.sv
module coinc_detect_chk
    import coinc_pkg::*;
#(
    parameter int NCH = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           hit_valid,
    input logic [NCH-1:0] hit_word,
    input coinc_state_e   state,
    input logic [NCH-1:0] prompt_sync
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> !hit_valid); // R8

    AST_NONZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_word != '0)); // R8

    AST_NO_HIT_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && state == ST_PAUSED) |=> !hit_valid); // R7

    AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKOUT && prompt_sync != '0) |=> !hit_valid); // R4

    AST_WORD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_word == $past(prompt_sync))); // R2

    AST_CAPTURE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (state == ST_LOCKOUT || state == ST_PAUSED)); // R5
endmodule

bind coinc_detect coinc_detect_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .hit_valid   (hit_valid),
    .hit_word    (hit_word),
    .state       (state_q),
    .prompt_sync (prompt_s)
);

// File: tb/coinc_detect_bench.sv
`timescale 1ns/1ps
module coinc_detect_bench;
    localparam int NCH = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run = 1'b0;
    logic [NCH-1:0] prompt_in = '0;
    logic [NCH-1:0] delayed_in = '0;
    logic           hit_valid;
    logic [NCH-1:0] hit_word;

    int n_checks = 0;
    int n_fail   = 0;
    int n_hits   = 0;
    int n_double = 0;
    int last_word = 0;
    int first_hit_cyc = -1;
    int cyc = 0;
    logic prev_valid = 1'b0;

    always #2 clk = ~clk;

    coinc_detect u_coinc_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .prompt_in  (prompt_in),
        .delayed_in (delayed_in),
        .hit_valid  (hit_valid),
        .hit_word   (hit_word)
    );

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (hit_valid) begin
            n_hits = n_hits + 1;
            last_word = int'(hit_word);
            if (first_hit_cyc < 0) first_hit_cyc = cyc;
            if (prev_valid) n_double = n_double + 1;
        end
        prev_valid = hit_valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon;
        n_hits = 0; n_double = 0; last_word = 0; first_hit_cyc = -1;
    endtask

    task automatic quiet;
        prompt_in = '0; delayed_in = '0;
        step(6);
    endtask

    task automatic t_reset;
        step(1);
        chk("R1 valid in reset", int'(hit_valid), 0);
        chk("R1 word in reset", int'(hit_word), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 valid after reset", int'(hit_valid), 0);
        chk("R1 word after reset", int'(hit_word), 0);
        run = 1'b1;
        step(4);
    endtask

    task automatic t_weights;
        int start;
        clear_mon();
        prompt_in = 11'b000_0000_0101;
        step(2);
        delayed_in = 11'b000_0000_0001;
        start = cyc;   // last edge before this drive
        step(6);
        chk("R2 A+C word", last_word, 5);
        chk("R2 one hit", n_hits, 1);
        chk("R3 latency", first_hit_cyc - start, 3);
        quiet();
    endtask

    task automatic t_late;
        clear_mon();
        prompt_in = 11'b000_0000_0011;
        delayed_in = 11'b000_0000_0001;
        step(1);
        prompt_in = 11'b000_0000_0111;
        step(1);
        delayed_in = 11'b000_0000_0011;
        step(6);
        chk("R3 late prompt excluded", last_word, 3);
        chk("R3 later edges one hit", n_hits, 1);
        quiet();
    endtask

    task automatic t_lockout;
        clear_mon();
        prompt_in = 11'b000_0000_0011;
        delayed_in = 11'b000_0000_0001;
        step(6);
        prompt_in = 11'b000_0000_0101;
        delayed_in = 11'b000_0000_0111;
        step(8);
        chk("R4 locked while prompts high", n_hits, 1);
        quiet();
        clear_mon();
        prompt_in = 11'b000_0000_1000;
        delayed_in = 11'b000_0000_1000;
        step(6);
        chk("R4 rearm after release", last_word, 8);
        chk("R4 rearm one hit", n_hits, 1);
        quiet();
    endtask

    task automatic t_simul;
        clear_mon();
        prompt_in = 11'b000_0011_0000;
        delayed_in = 11'b000_0011_0000;
        step(6);
        chk("R5 simultaneous one hit", n_hits, 1);
        chk("R5 simultaneous word", last_word, 48);
        quiet();
    endtask

    task automatic t_single;
        clear_mon();
        prompt_in = 11'b100_0000_0000;
        delayed_in = 11'b100_0000_0000;
        step(6);
        chk("R6 single emitted", n_hits, 1);
        chk("R6 single word", last_word, 1024);
        quiet();
    endtask

    task automatic t_all;
        clear_mon();
        prompt_in = '1;
        step(1);
        delayed_in = 11'b010_0000_0000;
        step(6);
        chk("R2 all channels", last_word, 2047);
        quiet();
    endtask

    task automatic t_pause;
        clear_mon();
        run = 1'b0;
        step(2);
        prompt_in = 11'b000_0000_0001;
        delayed_in = 11'b000_0000_0001;
        step(6);
        chk("R7 no hit while paused", n_hits, 0);
        run = 1'b1;
        step(6);
        chk("R7 held prompt across resume", n_hits, 0);
        quiet();
        prompt_in = 11'b000_0100_0000;
        delayed_in = 11'b000_0100_0000;
        step(6);
        chk("R7 resumes", last_word, 64);
        chk("R7 resume one hit", n_hits, 1);
        quiet();
    endtask

    task automatic t_zero;
        clear_mon();
        delayed_in = 11'b000_0000_0110;
        step(8);
        chk("R8 zero word not emitted", n_hits, 0);
        quiet();
        prompt_in = 11'b000_0000_0010;
        delayed_in = 11'b000_0000_0010;
        step(6);
        chk("R8 single-cycle strobe", n_double, 0);
        chk("R8 after zero capture", last_word, 2);
        quiet();
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_weights();
        t_late();
        t_lockout();
        t_simul();
        t_single();
        t_all();
        t_pause();
        t_zero();
        finish_run();
    end
endmodule